// File: doc/BRIEF.md
# Windowed Pixel Upload Engine

This block arms a rectangular update window and then counts the 16-bit words that a host pushes through a data port until the window is full. A setup checks the window corners, a source-select value and an input-format code. The format code gives the bytes per pixel. From that the block derives the number of 16-bit words the window needs. Each accepted word is passed to a staging buffer through a write enable, a word address and the data. The address starts at zero and advances by one per word.

When the last word lands, the block raises a one-cycle completion pulse and presents the window corners. It also grows a bounding dirty rectangle, which a later display refresh reads and then clears. A data-port word that arrives while no transfer is armed triggers a setup from the current window inputs. If that setup fails, the word is dropped. The rotation field is captured at setup and tells the downstream line writer whether to take the rotated or the straight path.

Top module: `pxw_upload_engine`

## Requirements
- R1: The bytes per pixel follow from `fmt_code`: code 1 gives 2, codes 2 and 3 give 3, codes 6 and 7 give 4. Every other code is unsupported, and a setup with it is rejected.
- R2: An armed window takes floor(bpp × (xe−xs+1) × (ye−ys+1) / 2) accepted words. `win_done` is high for exactly the cycle after the edge that takes the last of them.
- R3: A setup is rejected when `src_sel` > 3, when the format is unsupported, when `win_xe` < `win_xs`, or when `win_ye` < `win_ys`. `setup_rej` is set by a rejected setup and cleared by an accepted one. A rejected setup leaves any armed transfer and its address untouched.
- R4: Each accepted word asserts `buf_we` in the same cycle as `wr_stb`, with `buf_wdata` = `wr_data`. `buf_addr` is 0 for the first word of a window and goes up by one for each later word.
- R5: A `wr_stb` with no transfer armed first performs a setup from the current window inputs. If that setup is accepted, the word is taken at address 0. If it is rejected, `buf_we` stays low and the word is dropped.
- R6: While `win_done` is high, `done_x0`/`done_y0`/`done_x1`/`done_y1` hold the start and end corners of the completed window.
- R7: `rot_path` is 1 when `rot_sel` was nonzero at the last accepted setup and 0 when it was zero.
- R8: On completion, the minimum X and Y of the dirty rectangle drop to the window start if it is lower. The maximum X and Y rise to end+1 if that is higher. The dirty outputs change on the same edge that raises `win_done`.
- R9: After reset, and on the edge after `dirty_clr`, the dirty minimum equals (DISP_W, DISP_H) and the maximum equals (0, 0). A completion in the same cycle as a clear is applied after the clear.
- R10: A setup strobe while a transfer is armed and the new window is valid restarts the transfer. The address returns to 0 and the full new word count is required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_stb | input | 1 | Arm a window from the current window inputs |
| wr_stb | input | 1 | Data-port write strobe |
| wr_data | input | DATA_W | Data-port word |
| win_xs | input | COORD_W | Window start X |
| win_xe | input | COORD_W | Window end X (inclusive) |
| win_ys | input | COORD_W | Window start Y |
| win_ye | input | COORD_W | Window end Y (inclusive) |
| fmt_code | input | 4 | Input-format code |
| src_sel | input | 3 | Source select; values above 3 are illegal |
| rot_sel | input | 2 | Rotation field |
| dirty_clr | input | 1 | Empty the dirty rectangle |
| buf_we | output | 1 | Staging-buffer write enable |
| buf_addr | output | CNT_W | Staging-buffer word address |
| buf_wdata | output | DATA_W | Staging-buffer write data |
| rot_path | output | 1 | Rotated line path selected |
| win_done | output | 1 | Window complete, one-cycle pulse |
| done_x0 | output | COORD_W | Completed window start X |
| done_y0 | output | COORD_W | Completed window start Y |
| done_x1 | output | COORD_W | Completed window end X |
| done_y1 | output | COORD_W | Completed window end Y |
| setup_rej | output | 1 | Last setup was rejected |
| dirty_min_x | output | COORD_W+1 | Dirty rectangle minimum X |
| dirty_min_y | output | COORD_W+1 | Dirty rectangle minimum Y |
| dirty_max_x | output | COORD_W+1 | Dirty rectangle maximum X (exclusive) |
| dirty_max_y | output | COORD_W+1 | Dirty rectangle maximum Y (exclusive) |

## Verification
The bench aims at word counts that need the halving to truncate. A 3-bytes-per-pixel window with an odd pixel count is one such case. A design that rounds up there asks for an extra word, and its completion pulse arrives late. Each reject cause is tried on its own, and writes that land on an unarmed engine with illegal inputs must be dropped. A design that stores those words would show `buf_we` high. A rejected setup in the middle of a transfer must keep the address where it was. A re-setup must rewind it to zero. Any mix-up shows as a wrong `buf_addr`. A clear that meets a completion in the same cycle must keep the new window in the dirty rectangle. A design that lets the clear win would report an empty rectangle.

// File: rtl/pxw_pkg.sv
package pxw_pkg;
    typedef logic [2:0] bpp_t;
    localparam logic [2:0] SRC_LAST = 3'd3;
endpackage

// File: rtl/pxw_bpp_lut.sv
module pxw_bpp_lut
    import pxw_pkg::*;
(
    input  logic [3:0] fmt,
    output bpp_t       bpp
);
    always_comb begin
        unique case (fmt)
            4'd1:       bpp = 3'd2;
            4'd2, 4'd3: bpp = 3'd3;
            4'd6, 4'd7: bpp = 3'd4;
            default:    bpp = 3'd0;
        endcase
    end
endmodule

// File: rtl/pxw_win_check.sv
module pxw_win_check
    import pxw_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int CNT_W   = 2*COORD_W+4
) (
    input  logic [COORD_W-1:0] xs,
    input  logic [COORD_W-1:0] xe,
    input  logic [COORD_W-1:0] ys,
    input  logic [COORD_W-1:0] ye,
    input  logic [2:0]         src,
    input  bpp_t               bpp,
    output logic               ok,
    output logic [CNT_W-1:0]   words
);
    localparam int DIM_W  = COORD_W + 1;
    localparam int PROD_W = 3 + 2*DIM_W;

    logic [DIM_W-1:0]  width, height;
    logic [PROD_W-1:0] bytes;

    always_comb begin
        width  = {1'b0, xe} - {1'b0, xs} + DIM_W'(1);
        height = {1'b0, ye} - {1'b0, ys} + DIM_W'(1);
        bytes  = PROD_W'(bpp) * PROD_W'(width) * PROD_W'(height);
        words  = CNT_W'(bytes >> 1);
        ok     = (src <= SRC_LAST) && (bpp != 3'd0) && (xe >= xs) && (ye >= ys);
    end
endmodule

// File: rtl/pxw_dirty.sv
module pxw_dirty #(
    parameter int DIM_W  = 11,
    parameter int DISP_W = 640,
    parameter int DISP_H = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ext,
    input  logic [DIM_W-1:0] ex0,
    input  logic [DIM_W-1:0] ey0,
    input  logic [DIM_W-1:0] ex1,
    input  logic [DIM_W-1:0] ey1,
    output logic [DIM_W-1:0] min_x,
    output logic [DIM_W-1:0] min_y,
    output logic [DIM_W-1:0] max_x,
    output logic [DIM_W-1:0] max_y
);
    typedef struct packed {
        logic [DIM_W-1:0] mnx;
        logic [DIM_W-1:0] mny;
        logic [DIM_W-1:0] mxx;
        logic [DIM_W-1:0] mxy;
    } rect_t;

    localparam rect_t EMPTY = '{mnx: DIM_W'(DISP_W), mny: DIM_W'(DISP_H),
                                mxx: '0, mxy: '0};

    rect_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) r_d = EMPTY;
        if (ext) begin
            if (ex0 < r_d.mnx) r_d.mnx = ex0;
            if (ey0 < r_d.mny) r_d.mny = ey0;
            if (ex1 > r_d.mxx) r_d.mxx = ex1;
            if (ey1 > r_d.mxy) r_d.mxy = ey1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= EMPTY;
        else        r_q <= r_d;
    end

    assign min_x = r_q.mnx;
    assign min_y = r_q.mny;
    assign max_x = r_q.mxx;
    assign max_y = r_q.mxy;
endmodule

// File: rtl/pxw_upload_engine.sv
module pxw_upload_engine
    import pxw_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int DATA_W  = 16,
    parameter int DISP_W  = 640,
    parameter int DISP_H  = 480,
    localparam int DIM_W  = COORD_W + 1,
    localparam int CNT_W  = 2*COORD_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_stb,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [COORD_W-1:0] win_xs,
    input  logic [COORD_W-1:0] win_xe,
    input  logic [COORD_W-1:0] win_ys,
    input  logic [COORD_W-1:0] win_ye,
    input  logic [3:0]         fmt_code,
    input  logic [2:0]         src_sel,
    input  logic [1:0]         rot_sel,
    input  logic               dirty_clr,
    output logic               buf_we,
    output logic [CNT_W-1:0]   buf_addr,
    output logic [DATA_W-1:0]  buf_wdata,
    output logic               rot_path,
    output logic               win_done,
    output logic [COORD_W-1:0] done_x0,
    output logic [COORD_W-1:0] done_y0,
    output logic [COORD_W-1:0] done_x1,
    output logic [COORD_W-1:0] done_y1,
    output logic               setup_rej,
    output logic [DIM_W-1:0]   dirty_min_x,
    output logic [DIM_W-1:0]   dirty_min_y,
    output logic [DIM_W-1:0]   dirty_max_x,
    output logic [DIM_W-1:0]   dirty_max_y
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   ptr;
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] y0;
        logic [COORD_W-1:0] x1;
        logic [COORD_W-1:0] y1;
        logic               rot;
        logic               rej;
        logic               done;
    } eng_t;

    eng_t             st_d, st_q;
    bpp_t             bpp;
    logic             win_ok;
    logic [CNT_W-1:0] win_words;
    logic             setup_now;
    logic             take;

    pxw_bpp_lut i_lut (
        .fmt (fmt_code),
        .bpp (bpp)
    );

    pxw_win_check #(.COORD_W(COORD_W), .CNT_W(CNT_W)) i_chk_win (
        .xs    (win_xs),
        .xe    (win_xe),
        .ys    (win_ys),
        .ye    (win_ye),
        .src   (src_sel),
        .bpp   (bpp),
        .ok    (win_ok),
        .words (win_words)
    );

    // Setup (explicit, or implied by a write on an idle engine) is applied
    // first; the write then lands on whatever transfer is armed afterwards.
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        setup_now = setup_stb || (wr_stb && (st_q.cnt == '0));
        if (setup_now) begin
            if (win_ok) begin
                st_d.cnt = win_words;
                st_d.ptr = '0;
                st_d.x0  = win_xs;
                st_d.y0  = win_ys;
                st_d.x1  = win_xe;
                st_d.y1  = win_ye;
                st_d.rot = (rot_sel != 2'b00);
                st_d.rej = 1'b0;
            end else begin
                st_d.rej = 1'b1;
            end
        end
        take     = wr_stb && (st_d.cnt != '0);
        buf_addr = st_d.ptr;
        if (take) begin
            st_d.ptr  = st_d.ptr + CNT_W'(1);
            st_d.cnt  = st_d.cnt - CNT_W'(1);
            st_d.done = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pxw_dirty #(.DIM_W(DIM_W), .DISP_W(DISP_W), .DISP_H(DISP_H)) i_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dirty_clr),
        .ext   (st_d.done),
        .ex0   ({1'b0, st_d.x0}),
        .ey0   ({1'b0, st_d.y0}),
        .ex1   ({1'b0, st_d.x1} + DIM_W'(1)),
        .ey1   ({1'b0, st_d.y1} + DIM_W'(1)),
        .min_x (dirty_min_x),
        .min_y (dirty_min_y),
        .max_x (dirty_max_x),
        .max_y (dirty_max_y)
    );

    assign buf_we    = take;
    assign buf_wdata = wr_data;
    assign rot_path  = st_q.rot;
    assign win_done  = st_q.done;
    assign done_x0   = st_q.x0;
    assign done_y0   = st_q.y0;
    assign done_x1   = st_q.x1;
    assign done_y1   = st_q.y1;
    assign setup_rej = st_q.rej;
endmodule

// File: rtl/pxw_upload_chk.sv
module pxw_upload_chk #(
    parameter int COORD_W = 10,
    parameter int DISP_W  = 640,
    parameter int DISP_H  = 480,
    localparam int DIM_W  = COORD_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               setup_stb,
    input logic               wr_stb,
    input logic [3:0]         fmt_code,
    input logic [2:0]         src_sel,
    input logic               dirty_clr,
    input logic               buf_we,
    input logic               win_done,
    input logic [COORD_W-1:0] done_x0,
    input logic [COORD_W-1:0] done_y0,
    input logic [COORD_W-1:0] done_x1,
    input logic [COORD_W-1:0] done_y1,
    input logic               setup_rej,
    input logic [DIM_W-1:0]   dirty_min_x,
    input logic [DIM_W-1:0]   dirty_min_y,
    input logic [DIM_W-1:0]   dirty_max_x,
    input logic [DIM_W-1:0]   dirty_max_y
);
    // R4: nothing is stored without a port write
    p_we_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> wr_stb);

    // R2: completion only follows a port write
    p_done_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(wr_stb));

    // R1: an unsupported format code is rejected
    p_bad_fmt_rej_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_stb && fmt_code == 4'd0) |=> setup_rej);

    // R3: illegal source select is rejected
    p_bad_src_rej_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_stb && src_sel > 3'd3) |=> setup_rej);

    // R8: a completed window lies inside the dirty rectangle
    p_dirty_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (dirty_min_x <= {1'b0, done_x0}) && (dirty_min_y <= {1'b0, done_y0})
                  && (dirty_max_x >  {1'b0, done_x1}) && (dirty_max_y >  {1'b0, done_y1}));

    // R9: a clear without any write leaves the rectangle empty
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_clr && !wr_stb) |=> (dirty_max_x == '0) && (dirty_max_y == '0)
            && (dirty_min_x == DIM_W'(DISP_W)) && (dirty_min_y == DIM_W'(DISP_H)));
endmodule

bind pxw_upload_engine pxw_upload_chk #(
    .COORD_W (COORD_W),
    .DISP_W  (DISP_W),
    .DISP_H  (DISP_H)
) i_upload_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_stb   (setup_stb),
    .wr_stb      (wr_stb),
    .fmt_code    (fmt_code),
    .src_sel     (src_sel),
    .dirty_clr   (dirty_clr),
    .buf_we      (buf_we),
    .win_done    (win_done),
    .done_x0     (done_x0),
    .done_y0     (done_y0),
    .done_x1     (done_x1),
    .done_y1     (done_y1),
    .setup_rej   (setup_rej),
    .dirty_min_x (dirty_min_x),
    .dirty_min_y (dirty_min_y),
    .dirty_max_x (dirty_max_x),
    .dirty_max_y (dirty_max_y)
);

// File: tb/test_pxw_upload_engine.sv
`timescale 1ns/1ps
module test_pxw_upload_engine;
    localparam int COORD_W = 10;
    localparam int DATA_W  = 16;
    localparam int DISP_W  = 640;
    localparam int DISP_H  = 480;
    localparam int DIM_W   = COORD_W + 1;
    localparam int CNT_W   = 2*COORD_W + 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               setup_stb = 1'b0, wr_stb = 1'b0, dirty_clr = 1'b0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [COORD_W-1:0] win_xs = '0, win_xe = '0, win_ys = '0, win_ye = '0;
    logic [3:0]         fmt_code = 4'd3;
    logic [2:0]         src_sel = '0;
    logic [1:0]         rot_sel = '0;
    logic               buf_we, rot_path, win_done, setup_rej;
    logic [CNT_W-1:0]   buf_addr;
    logic [DATA_W-1:0]  buf_wdata;
    logic [COORD_W-1:0] done_x0, done_y0, done_x1, done_y1;
    logic [DIM_W-1:0]   dirty_min_x, dirty_min_y, dirty_max_x, dirty_max_y;

    always #2.5 clk = ~clk;

    pxw_upload_engine #(.COORD_W(COORD_W), .DATA_W(DATA_W),
                        .DISP_W(DISP_W), .DISP_H(DISP_H)) i_pxw_upload_engine (
        .clk(clk), .rst_n(rst_n), .setup_stb(setup_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .win_xs(win_xs), .win_xe(win_xe), .win_ys(win_ys),
        .win_ye(win_ye), .fmt_code(fmt_code), .src_sel(src_sel), .rot_sel(rot_sel),
        .dirty_clr(dirty_clr), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .rot_path(rot_path), .win_done(win_done),
        .done_x0(done_x0), .done_y0(done_y0), .done_x1(done_x1), .done_y1(done_y1),
        .setup_rej(setup_rej), .dirty_min_x(dirty_min_x), .dirty_min_y(dirty_min_y),
        .dirty_max_x(dirty_max_x), .dirty_max_y(dirty_max_y));

    typedef struct packed {
        logic [3:0]  fmt;
        logic [2:0]  src;
        logic [9:0]  xs, xe, ys, ye;
        logic [1:0]  rot;
        logic [15:0] words;
        logic        rej;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TAB [NV] = '{
        '{4'd1, 3'd0, 10'd10,   10'd11,   10'd20,  10'd21,  2'd0, 16'd4,  1'b0},
        '{4'd2, 3'd1, 10'd5,    10'd7,    10'd3,   10'd3,   2'd1, 16'd4,  1'b0},
        '{4'd3, 3'd3, 10'd100,  10'd100,  10'd50,  10'd50,  2'd2, 16'd1,  1'b0},
        '{4'd6, 3'd2, 10'd0,    10'd1,    10'd200, 10'd202, 2'd3, 16'd12, 1'b0},
        '{4'd7, 3'd0, 10'd300,  10'd300,  10'd7,   10'd8,   2'd0, 16'd4,  1'b0},
        '{4'd0, 3'd0, 10'd1,    10'd2,    10'd1,   10'd2,   2'd0, 16'd0,  1'b1},
        '{4'd5, 3'd0, 10'd1,    10'd2,    10'd1,   10'd2,   2'd0, 16'd0,  1'b1},
        '{4'd3, 3'd4, 10'd1,    10'd2,    10'd1,   10'd2,   2'd0, 16'd0,  1'b1},
        '{4'd1, 3'd0, 10'd12,   10'd11,   10'd1,   10'd2,   2'd0, 16'd0,  1'b1},
        '{4'd1, 3'd0, 10'd1,    10'd2,    10'd9,   10'd8,   2'd0, 16'd0,  1'b1},
        '{4'd3, 3'd0, 10'd1000, 10'd1001, 10'd470, 10'd470, 2'd1, 16'd3,  1'b0}
    };

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int m_mnx, m_mny, m_mxx, m_mxy;

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic check_dirty(input string tag);
        check(int'(dirty_min_x) == m_mnx, {tag, " min_x"}, int'(dirty_min_x), m_mnx);
        check(int'(dirty_min_y) == m_mny, {tag, " min_y"}, int'(dirty_min_y), m_mny);
        check(int'(dirty_max_x) == m_mxx, {tag, " max_x"}, int'(dirty_max_x), m_mxx);
        check(int'(dirty_max_y) == m_mxy, {tag, " max_y"}, int'(dirty_max_y), m_mxy);
    endtask

    task automatic set_win(input vec_t v);
        fmt_code = v.fmt; src_sel = v.src; rot_sel = v.rot;
        win_xs = v.xs; win_xe = v.xe; win_ys = v.ys; win_ye = v.ye;
    endtask

    // Called at edge+1; returns at edge+1 of the next cycle.
    task automatic do_setup(input vec_t v);
        set_win(v);
        setup_stb = 1'b1;
        @(posedge clk); #1;
        setup_stb = 1'b0;
    endtask

    task automatic put_word(input bit exp_we, input int exp_addr, input bit exp_done,
                            input string tag);
        wr_stb  = 1'b1;
        wr_data = 16'(16'hA500 + exp_addr + n_chk);
        #1;
        check(buf_we == exp_we, {tag, " buf_we"}, int'(buf_we), int'(exp_we));
        if (exp_we) begin
            check(int'(buf_addr) == exp_addr, {tag, " buf_addr"}, int'(buf_addr), exp_addr);
            check(buf_wdata == wr_data, "R4 buf_wdata", int'(buf_wdata), int'(wr_data));
        end
        @(posedge clk); #1;
        wr_stb = 1'b0;
        check(win_done == exp_done, {tag, " win_done"}, int'(win_done), int'(exp_done));
    endtask

    task automatic model_extend(input int x0, input int y0, input int x1, input int y1);
        if (x0 < m_mnx) m_mnx = x0;
        if (y0 < m_mny) m_mny = y0;
        if (x1 + 1 > m_mxx) m_mxx = x1 + 1;
        if (y1 + 1 > m_mxy) m_mxy = y1 + 1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        vec_t v;
        m_mnx = DISP_W; m_mny = DISP_H; m_mxx = 0; m_mxy = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // Reset state (R9)
        check_dirty("R9 reset");
        check(win_done == 1'b0, "R2 reset win_done", int'(win_done), 0);
        check(setup_rej == 1'b0, "R3 reset setup_rej", int'(setup_rej), 0);
        check(buf_we == 1'b0, "R4 reset buf_we", int'(buf_we), 0);

        // Table walk: R1, R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            v = TAB[i];
            do_setup(v);
            check(setup_rej == v.rej, "R1/R3 setup_rej", int'(setup_rej), int'(v.rej));
            if (!v.rej) begin
                check(rot_path == (v.rot != 2'd0), "R7 rot_path", int'(rot_path),
                      int'(v.rot != 2'd0));
                for (int k = 0; k < int'(v.words); k++)
                    put_word(1'b1, k, k == int'(v.words) - 1, "R2/R4 word");
                check(done_x0 == v.xs && done_y0 == v.ys, "R6 done start",
                      int'(done_x0) * 1024 + int'(done_y0), int'(v.xs) * 1024 + int'(v.ys));
                check(done_x1 == v.xe && done_y1 == v.ye, "R6 done end",
                      int'(done_x1) * 1024 + int'(done_y1), int'(v.xe) * 1024 + int'(v.ye));
                model_extend(int'(v.xs), int'(v.ys), int'(v.xe), int'(v.ye));
                check_dirty("R8 extend");
            end else begin
                // idle engine, illegal inputs: implied setup fails, word dropped
                put_word(1'b0, 0, 1'b0, "R5 dropped");
                check(setup_rej == 1'b1, "R5 implied setup rej", int'(setup_rej), 1);
                check_dirty("R8 unchanged after reject");
            end
        end

        // Clear (R9)
        dirty_clr = 1'b1;
        @(posedge clk); #1;
        dirty_clr = 1'b0;
        m_mnx = DISP_W; m_mny = DISP_H; m_mxx = 0; m_mxy = 0;
        check_dirty("R9 clear");

        // Implied setup accepted, completion in the same cycle as a clear (R5, R9)
        set_win('{4'd3, 3'd0, 10'd33, 10'd33, 10'd44, 10'd44, 2'd0, 16'd1, 1'b0});
        dirty_clr = 1'b1;
        put_word(1'b1, 0, 1'b1, "R5 implied setup");
        dirty_clr = 1'b0;
        m_mnx = 33; m_mny = 44; m_mxx = 34; m_mxy = 45;
        check_dirty("R9 clear then extend");

        // Restart while armed (R10): 2x2 at 2 bytes/pixel = 4 words
        v = '{4'd1, 3'd0, 10'd0, 10'd1, 10'd0, 10'd1, 2'd0, 16'd4, 1'b0};
        do_setup(v);
        put_word(1'b1, 0, 1'b0, "R10 first");
        put_word(1'b1, 1, 1'b0, "R10 second");
        do_setup(v);
        for (int k = 0; k < 4; k++)
            put_word(1'b1, k, k == 3, "R10 restarted");

        // Rejected setup mid-transfer keeps the armed transfer (R3)
        do_setup(v);
        put_word(1'b1, 0, 1'b0, "R3 before reject");
        do_setup('{4'd0, 3'd0, 10'd0, 10'd1, 10'd0, 10'd1, 2'd0, 16'd0, 1'b1});
        check(setup_rej == 1'b1, "R3 mid-transfer reject", int'(setup_rej), 1);
        for (int k = 1; k < 4; k++)
            put_word(1'b1, k, k == 3, "R3 kept transfer");

        finish_run();
    end
endmodule